// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the command side of a parallel NOR flash that follows the common two-cycle command protocol. A host drives a simple synchronous bus: a word address, write data, a write strobe and a read strobe. Every write is decoded as a command byte (low eight bits of `wr_data`) or as a data or argument cycle, depending on a latched command byte and a small write-cycle counter. The block supports single-word program, block erase, buffered multi-word write with a count cycle and a confirm cycle, status clearing, a lock argument sequence, and four read modes: array, status, identifier and query.

The data bus is built from `DATA_W/DEV_W` identical devices in parallel. Status, identifier and query bytes are therefore returned in every `DEV_W`-wide lane of the read word. The storage is an internal register file of `NUM_BLOCKS` blocks of `BLOCK_WORDS` words each, so erase and program results can be read back directly. A read-only strap turns every program and erase into an error report that leaves the array untouched. A read returns its value on `rd_data` one clock after `rd_en`.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset every array word reads 0xFFFF, the read mode is array, the status byte is 0x00 and the cycle counter is 0.
- R2: In the idle cycle, 0x10 or 0x40 arms a program. The next write stores its data at its address, sets status bit 7 (ready) and returns the cycle counter to 0.
- R3: In the idle cycle, 0x20 clears the block that holds the address to all ones at once, sets ready and waits for a second cycle. Words in other blocks keep their contents.
- R4: In the second erase cycle, 0xD0 sets ready and returns to idle, and 0xFF returns to array mode. Any other byte pulses `seq_err` for one cycle and returns to array mode.
- R5: 0x50 sets the status byte to 0x00 and selects array mode. 0x00, 0xF0 and 0xFF each select array mode.
- R6: 0x70 selects status read and 0x90 selects identifier read, and neither advances the cycle counter. In identifier mode, address 0 returns `MFR_ID`, address 1 returns `DEV_ID` and every other address returns 0, each byte repeated in every lane.
- R7: 0x98 selects query mode. Address 0x10/0x11/0x12 return 0x51/0x52/0x59, 0x13 returns 0x01, 0x27 returns log2 of the device size in bytes and 0x2D returns `NUM_BLOCKS-1`, each repeated in every lane. Only 0xFF leaves query mode.
- R8: 0xE8 starts a buffered write. The next write gives a count N taken from the low `DEV_W` bits of the data, the following N+1 writes each store one word, and then 0xD0 returns to idle. Any other confirm byte pulses `seq_err` and selects array mode.
- R9: While `ro_strap` is high, the array is never changed. A program or buffered-write data cycle sets status bit 4 and an erase sets status bit 5, and ready (bit 7) is still set.
- R10: After 0x60, a second byte of 0xD0 or 0x01 sets ready and returns to idle. Any other second byte selects array mode without an error.
- R11: While the latched command is program, erase, lock, status or buffered write, a read returns the status byte in every lane instead of array data.
- R12: An unknown command byte in the idle cycle pulses `seq_err` for one cycle and forces array mode with the cycle counter at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ro_strap | input | 1 | Read-only strap; blocks all array changes |
| wr_en | input | 1 | Write strobe, one bus write per cycle |
| rd_en | input | 1 | Read strobe; data appears one cycle later |
| addr | input | ADDR_W (7) | Word address |
| wr_data | input | DATA_W (16) | Write data; the low byte is the command byte |
| rd_data | output | DATA_W (16) | Registered read data |
| seq_err | output | 1 | One-cycle pulse on an unsupported command sequence |

## Verification
The embedded assertions check on every cycle that the buffered-write data and confirm cycles only occur under the 0xE8 command, and that a program data cycle always leaves ready set and the counter at idle. They also check that clear-status and the status/identifier selects have the right effect on the next cycle, that an error pulse coincides with array mode, and that no array change is requested while the strap is high. Only the bench scenarios can show the end results: the alignment and extent of a block erase, the exact word count of a buffered write, the lane replication of identifier and query bytes, and that a read-only attempt leaves earlier data intact.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
   // command byte values decoded by the sequencer
   localparam logic [7:0] OP_ARRAY   = 8'h00;
   localparam logic [7:0] OP_PROG_A  = 8'h10;
   localparam logic [7:0] OP_ERASE   = 8'h20;
   localparam logic [7:0] OP_PROG_B  = 8'h40;
   localparam logic [7:0] OP_CLEAR   = 8'h50;
   localparam logic [7:0] OP_LOCK    = 8'h60;
   localparam logic [7:0] OP_STATUS  = 8'h70;
   localparam logic [7:0] OP_IDENT   = 8'h90;
   localparam logic [7:0] OP_QUERY   = 8'h98;
   localparam logic [7:0] OP_BUFWR   = 8'hE8;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_UNLOCK  = 8'h01;
   localparam logic [7:0] OP_ALTRST  = 8'hF0;
   localparam logic [7:0] OP_RESET   = 8'hFF;

   // status byte flags
   localparam logic [7:0] ST_READY    = 8'h80;
   localparam logic [7:0] ST_ERASEERR = 8'h20;
   localparam logic [7:0] ST_PROGERR  = 8'h10;

   function automatic logic shows_status(input logic [7:0] c);
      return (c == OP_PROG_A) || (c == OP_PROG_B) || (c == OP_ERASE) ||
             (c == OP_CLEAR)  || (c == OP_LOCK)   || (c == OP_STATUS) ||
             (c == OP_BUFWR);
   endfunction
endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
   import nor_cmd_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEV_W  = 8,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ro_strap,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              prog_en,
   output logic              erase_en,
   output logic [7:0]        cmd_q,
   output logic [7:0]        status_q,
   output logic              seq_err
);
   logic [1:0]       wcyc_q, wcyc_d;
   logic [7:0]       cmd_d, status_d;
   logic [DEV_W-1:0] cnt_q, cnt_d;
   logic             err_d;
   logic [7:0]       op;

   assign op = wr_data[7:0];

   always_comb begin
      wcyc_d   = wcyc_q;
      cmd_d    = cmd_q;
      status_d = status_q;
      cnt_d    = cnt_q;
      err_d    = 1'b0;
      prog_en  = 1'b0;
      erase_en = 1'b0;
      if (wr_en) begin
         case (wcyc_q)
            2'd0: begin
               case (op)
                  OP_ARRAY, OP_ALTRST, OP_RESET: begin
                     wcyc_d = 2'd0;
                     cmd_d  = OP_ARRAY;
                  end
                  OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
                     wcyc_d = 2'd1;
                     cmd_d  = op;
                  end
                  OP_ERASE: begin
                     erase_en = !ro_strap;
                     status_d = status_q | ST_READY | (ro_strap ? ST_ERASEERR : 8'h00);
                     wcyc_d   = 2'd1;
                     cmd_d    = op;
                  end
                  OP_CLEAR: begin
                     status_d = 8'h00;
                     wcyc_d   = 2'd0;
                     cmd_d    = OP_ARRAY;
                  end
                  OP_STATUS, OP_IDENT: cmd_d = op;
                  OP_BUFWR: begin
                     status_d = status_q | ST_READY;
                     wcyc_d   = 2'd1;
                     cmd_d    = op;
                  end
                  default: begin
                     err_d  = 1'b1;
                     wcyc_d = 2'd0;
                     cmd_d  = OP_ARRAY;
                  end
               endcase
            end
            2'd1: begin
               case (cmd_q)
                  OP_PROG_A, OP_PROG_B: begin
                     prog_en  = !ro_strap;
                     status_d = status_q | ST_READY | (ro_strap ? ST_PROGERR : 8'h00);
                     wcyc_d   = 2'd0;
                  end
                  OP_ERASE: begin
                     if (op == OP_CONFIRM) begin
                        status_d = status_q | ST_READY;
                        wcyc_d   = 2'd0;
                     end else begin
                        err_d  = (op != OP_RESET);
                        wcyc_d = 2'd0;
                        cmd_d  = OP_ARRAY;
                     end
                  end
                  OP_BUFWR: begin
                     cnt_d  = wr_data[DEV_W-1:0];
                     wcyc_d = 2'd2;
                  end
                  OP_LOCK: begin
                     if (op == OP_CONFIRM || op == OP_UNLOCK) begin
                        status_d = status_q | ST_READY;
                        wcyc_d   = 2'd0;
                     end else begin
                        wcyc_d = 2'd0;
                        cmd_d  = OP_ARRAY;
                     end
                  end
                  OP_QUERY: begin
                     if (op == OP_RESET) begin
                        wcyc_d = 2'd0;
                        cmd_d  = OP_ARRAY;
                     end
                  end
                  default: begin
                     err_d  = 1'b1;
                     wcyc_d = 2'd0;
                     cmd_d  = OP_ARRAY;
                  end
               endcase
            end
            2'd2: begin
               if (cmd_q == OP_BUFWR) begin
                  prog_en  = !ro_strap;
                  status_d = status_q | ST_READY | (ro_strap ? ST_PROGERR : 8'h00);
                  if (cnt_q == '0) wcyc_d = 2'd3;
                  cnt_d = cnt_q - 1'b1;
               end else begin
                  err_d  = 1'b1;
                  wcyc_d = 2'd0;
                  cmd_d  = OP_ARRAY;
               end
            end
            default: begin
               if (cmd_q == OP_BUFWR && op == OP_CONFIRM) begin
                  status_d = status_q | ST_READY;
                  wcyc_d   = 2'd0;
               end else begin
                  err_d  = 1'b1;
                  wcyc_d = 2'd0;
                  cmd_d  = OP_ARRAY;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcyc_q   <= 2'd0;
         cmd_q    <= OP_ARRAY;
         status_q <= 8'h00;
         cnt_q    <= '0;
         seq_err  <= 1'b0;
      end else begin
         wcyc_q   <= wcyc_d;
         cmd_q    <= cmd_d;
         status_q <= status_d;
         cnt_q    <= cnt_d;
         seq_err  <= err_d;
      end
   end

   // R8: data and confirm cycles only exist under the buffered-write command
   assert_deep_cycle_bufwr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wcyc_q[1] |-> (cmd_q == OP_BUFWR));

   // R2: a program data cycle leaves ready set and the counter idle
   assert_prog_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wcyc_q == 2'd0 && (op == OP_PROG_A || op == OP_PROG_B)) ##1
      (wr_en && wcyc_q == 2'd1) |=> (status_q[7] && wcyc_q == 2'd0));

   // R5: clear-status empties the status byte and selects array mode
   assert_clear_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wcyc_q == 2'd0 && op == OP_CLEAR) |=> (status_q == 8'h00 && cmd_q == OP_ARRAY));

   // R6: status and identifier selects keep the counter at idle
   assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wcyc_q == 2'd0 && (op == OP_STATUS || op == OP_IDENT))
      |=> (wcyc_q == 2'd0 && cmd_q == $past(op)));

   // R12: an error pulse always coincides with array mode at idle
   assert_err_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |-> (wcyc_q == 2'd0 && cmd_q == OP_ARRAY));
endmodule

// File: rtl/nor_array.sv
module nor_array #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 7,
   parameter int BLK_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic              erase_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rword
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
      end else if (erase_en) begin
         for (int i = 0; i < WORDS; i++) begin
            if ((i >> BLK_W) == (int'(addr) >> BLK_W)) mem_q[i] <= '1;
         end
      end else if (prog_en) begin
         mem_q[addr] <= wdata;
      end
   end

   assign rword = mem_q[addr];
endmodule

// File: rtl/nor_rd_mux.sv
module nor_rd_mux
   import nor_cmd_pkg::*;
#(
   parameter int         DATA_W     = 16,
   parameter int         DEV_W      = 8,
   parameter int         ADDR_W     = 7,
   parameter int         NUM_BLOCKS = 4,
   parameter int         SIZE_LOG2  = 7,
   parameter logic [7:0] MFR_ID     = 8'h89,
   parameter logic [7:0] DEV_ID     = 8'h18
) (
   input  logic [7:0]        cmd,
   input  logic [7:0]        status,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] arr_word,
   output logic [DATA_W-1:0] value
);
   localparam int LANES = DATA_W / DEV_W;

   function automatic logic [7:0] query_byte(input int unsigned off);
      case (off)
         32'h10:  return 8'h51;
         32'h11:  return 8'h52;
         32'h12:  return 8'h59;
         32'h13:  return 8'h01;
         32'h15:  return 8'h31;
         32'h27:  return 8'(SIZE_LOG2);
         32'h2C:  return 8'h01;
         32'h2D:  return 8'(NUM_BLOCKS - 1);
         default: return 8'h00;
      endcase
   endfunction

   logic [7:0]        lane_byte;
   logic              use_array;
   logic [DATA_W-1:0] lanes;

   always_comb begin
      use_array = 1'b0;
      lane_byte = 8'h00;
      if (shows_status(cmd)) begin
         lane_byte = status;
      end else if (cmd == OP_IDENT) begin
         if (addr == ADDR_W'(0))      lane_byte = MFR_ID;
         else if (addr == ADDR_W'(1)) lane_byte = DEV_ID;
      end else if (cmd == OP_QUERY) begin
         lane_byte = query_byte(int'(addr));
      end else begin
         use_array = 1'b1;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (DEV_W == 8) begin : g_byte
         assign lanes[l*DEV_W +: DEV_W] = lane_byte;
      end else begin : g_wide
         assign lanes[l*DEV_W +: DEV_W] = {{(DEV_W-8){1'b0}}, lane_byte};
      end
   end

   assign value = use_array ? arr_word : lanes;
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_cmd_pkg::*;
#(
   parameter int         DATA_W      = 16,
   parameter int         DEV_W       = 8,
   parameter int         NUM_BLOCKS  = 4,
   parameter int         BLOCK_WORDS = 32,
   parameter logic [7:0] MFR_ID      = 8'h89,
   parameter logic [7:0] DEV_ID      = 8'h18,
   localparam int        WORDS       = NUM_BLOCKS * BLOCK_WORDS,
   localparam int        ADDR_W      = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ro_strap,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              seq_err
);
   localparam int BLK_W     = $clog2(BLOCK_WORDS);
   localparam int SIZE_LOG2 = ADDR_W + $clog2(DEV_W / 8);

   if (DEV_W < 8 || DEV_W % 8 != 0 || DATA_W % DEV_W != 0) begin : g_bad_width
      $error("nor_cmd_seq: DEV_W must be a byte multiple dividing DATA_W");
   end
   if (NUM_BLOCKS < 2 || (NUM_BLOCKS & (NUM_BLOCKS - 1)) != 0) begin : g_bad_blocks
      $error("nor_cmd_seq: NUM_BLOCKS must be a power of two of at least 2");
   end
   if (BLOCK_WORDS < 2 || (BLOCK_WORDS & (BLOCK_WORDS - 1)) != 0) begin : g_bad_bwords
      $error("nor_cmd_seq: BLOCK_WORDS must be a power of two");
   end

   logic              prog_en, erase_en;
   logic [7:0]        cmd_q, status_q;
   logic [DATA_W-1:0] arr_word, rd_value;

   nor_cmd_fsm #(.DATA_W(DATA_W), .DEV_W(DEV_W), .ADDR_W(ADDR_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .ro_strap(ro_strap), .wr_en(wr_en),
      .wr_data(wr_data), .prog_en(prog_en), .erase_en(erase_en),
      .cmd_q(cmd_q), .status_q(status_q), .seq_err(seq_err)
   );

   nor_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .erase_en(erase_en),
      .addr(addr), .wdata(wr_data), .rword(arr_word)
   );

   nor_rd_mux #(
      .DATA_W(DATA_W), .DEV_W(DEV_W), .ADDR_W(ADDR_W), .NUM_BLOCKS(NUM_BLOCKS),
      .SIZE_LOG2(SIZE_LOG2), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
   ) u_mux (
      .cmd(cmd_q), .status(status_q), .addr(addr), .arr_word(arr_word), .value(rd_value)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_value;
   end

   // R9: no array change is requested while the strap is high
   assert_ro_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ro_strap |-> !(prog_en || erase_en));
endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ro_strap = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [6:0]  addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        seq_err;
   logic        last_err;
   int          n_chk = 0;
   int          n_fail = 0;
   int          cycles = 0;

   always #10 clk = ~clk;

   nor_cmd_seq u_dut (
      .clk(clk), .rst_n(rst_n), .ro_strap(ro_strap), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .seq_err(seq_err)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 20000)", cycles);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      last_err = seq_err;
   endtask

   task automatic rd_chk(input string tag, input logic [6:0] a, input logic [15:0] exp);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check(tag, rd_data, exp);
   endtask

   task automatic t_reset;
      rd_chk("R1 erased array after reset", 7'd5, 16'hFFFF);
      wr(7'd0, 16'h0070);
      check("R1 no error on status select", {15'd0, last_err}, 16'd0);
      rd_chk("R1 status zero after reset", 7'd0, 16'h0000);
   endtask

   task automatic t_program;
      wr(7'd0, 16'h0040);
      wr(7'd3, 16'h1234);
      rd_chk("R11 status shown after program", 7'd9, 16'h8080);
      wr(7'd0, 16'h00FF);
      rd_chk("R2 word stored by 0x40", 7'd3, 16'h1234);
      wr(7'd0, 16'h0010);
      wr(7'd40, 16'hA5A5);
      wr(7'd0, 16'h00FF);
      rd_chk("R2 word stored by 0x10", 7'd40, 16'hA5A5);
   endtask

   task automatic t_erase;
      wr(7'd0, 16'h0050);
      wr(7'd35, 16'h0020);
      rd_chk("R11 status in erase first cycle", 7'd0, 16'h8080);
      wr(7'd0, 16'h00D0);
      check("R4 confirm raises no error", {15'd0, last_err}, 16'd0);
      rd_chk("R4 status after confirm", 7'd0, 16'h8080);
      wr(7'd0, 16'h00FF);
      rd_chk("R3 erased word in block", 7'd40, 16'hFFFF);
      rd_chk("R3 other block untouched", 7'd3, 16'h1234);
      wr(7'd5, 16'h0020);
      wr(7'd0, 16'h00FF);
      check("R4 0xFF second cycle no error", {15'd0, last_err}, 16'd0);
      rd_chk("R3 aligned erase of block 0", 7'd3, 16'hFFFF);
      wr(7'd0, 16'h0020);
      wr(7'd0, 16'h0033);
      check("R4 bad second byte errors", {15'd0, last_err}, 16'd1);
      rd_chk("R4 array mode after bad byte", 7'd3, 16'hFFFF);
   endtask

   task automatic t_clear;
      wr(7'd0, 16'h0050);
      rd_chk("R5 array mode after clear", 7'd3, 16'hFFFF);
      wr(7'd0, 16'h0070);
      rd_chk("R5 status cleared", 7'd0, 16'h0000);
      wr(7'd0, 16'h00F0);
      rd_chk("R5 0xF0 selects array", 7'd3, 16'hFFFF);
      wr(7'd0, 16'h0090);
      wr(7'd0, 16'h0000);
      rd_chk("R5 0x00 selects array", 7'd0, 16'hFFFF);
   endtask

   task automatic t_ident;
      wr(7'd0, 16'h0090);
      rd_chk("R6 maker id", 7'd0, 16'h8989);
      rd_chk("R6 device id", 7'd1, 16'h1818);
      rd_chk("R6 other id address", 7'd2, 16'h0000);
      wr(7'd0, 16'h0070);
      rd_chk("R6 status select from id mode", 7'd0, 16'h0000);
      wr(7'd0, 16'h00FF);
   endtask

   task automatic t_query;
      wr(7'd0, 16'h0098);
      rd_chk("R7 query Q", 7'h10, 16'h5151);
      rd_chk("R7 query R", 7'h11, 16'h5252);
      rd_chk("R7 query Y", 7'h12, 16'h5959);
      rd_chk("R7 query size", 7'h27, 16'h0707);
      rd_chk("R7 query blocks", 7'h2D, 16'h0303);
      wr(7'd0, 16'h0000);
      rd_chk("R7 query held on non-FF", 7'h10, 16'h5151);
      wr(7'd0, 16'h00FF);
      rd_chk("R7 query left on FF", 7'h10, 16'hFFFF);
   endtask

   task automatic t_buffer;
      wr(7'd0, 16'h0050);
      wr(7'd64, 16'h00E8);
      wr(7'd64, 16'h0102);
      wr(7'd64, 16'h1111);
      wr(7'd65, 16'h2222);
      wr(7'd66, 16'h3333);
      wr(7'd0, 16'h00D0);
      check("R8 confirm no error", {15'd0, last_err}, 16'd0);
      rd_chk("R11 status after buffered write", 7'd0, 16'h8080);
      wr(7'd0, 16'h00FF);
      rd_chk("R8 buffered word 0", 7'd64, 16'h1111);
      rd_chk("R8 buffered word 1", 7'd65, 16'h2222);
      rd_chk("R8 buffered word 2", 7'd66, 16'h3333);
      rd_chk("R8 count masked to device width", 7'd67, 16'hFFFF);
      wr(7'd80, 16'h00E8);
      wr(7'd80, 16'h0000);
      wr(7'd80, 16'h4444);
      wr(7'd0, 16'h0077);
      check("R8 bad confirm errors", {15'd0, last_err}, 16'd1);
      rd_chk("R8 single word stored", 7'd80, 16'h4444);
   endtask

   task automatic t_readonly;
      ro_strap = 1'b1;
      wr(7'd0, 16'h0050);
      wr(7'd0, 16'h0040);
      wr(7'd70, 16'h0000);
      rd_chk("R9 program error flag", 7'd0, 16'h9090);
      wr(7'd0, 16'h00FF);
      rd_chk("R9 program blocked", 7'd70, 16'hFFFF);
      wr(7'd0, 16'h0050);
      wr(7'd64, 16'h0020);
      rd_chk("R9 erase error flag", 7'd0, 16'hA0A0);
      wr(7'd0, 16'h00D0);
      wr(7'd0, 16'h00FF);
      rd_chk("R9 erase blocked", 7'd64, 16'h1111);
      wr(7'd0, 16'h0050);
      wr(7'd68, 16'h00E8);
      wr(7'd68, 16'h0000);
      wr(7'd68, 16'h5555);
      rd_chk("R9 buffered error flag", 7'd0, 16'h9090);
      wr(7'd0, 16'h00D0);
      wr(7'd0, 16'h00FF);
      rd_chk("R9 buffered write blocked", 7'd68, 16'hFFFF);
      ro_strap = 1'b0;
   endtask

   task automatic t_lock;
      wr(7'd0, 16'h0050);
      wr(7'd0, 16'h0060);
      wr(7'd0, 16'h0001);
      rd_chk("R10 unlock argument accepted", 7'd0, 16'h8080);
      wr(7'd0, 16'h0060);
      wr(7'd0, 16'h00D0);
      rd_chk("R10 lock argument accepted", 7'd0, 16'h8080);
      wr(7'd0, 16'h0060);
      wr(7'd0, 16'h0044);
      check("R10 other argument no error", {15'd0, last_err}, 16'd0);
      rd_chk("R10 other argument array mode", 7'd64, 16'h1111);
   endtask

   task automatic t_unknown;
      wr(7'd0, 16'h0033);
      check("R12 unknown command errors", {15'd0, last_err}, 16'd1);
      rd_chk("R12 array mode after unknown", 7'd64, 16'h1111);
      wr(7'd0, 16'h00FF);
      check("R12 error is a single pulse", {15'd0, last_err}, 16'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_program();
      t_erase();
      t_clear();
      t_ident();
      t_query();
      t_buffer();
      t_readonly();
      t_lock();
      t_unknown();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule